// File: doc/BRIEF.md
# Rotating-Schedule Crossbar Switch

A six-port by six-port crossbar with 16-bit ports whose routing is set by an internal schedule rather than by a host or arbiter. Three inputs take words from external pseudorandom sources. The other three inputs are fixed at zero. Three outputs drive a downstream counter bank, and the other three drive dummy loads.

An 8-bit phase counter runs freely. Each time it rolls over, a rotation index advances. Output j is fed from input (j + k) mod 6, where k is the rotation index. As a result, every live input visits every output in turn, and each mapping stays in place for 256 cycles. Outputs are registered. The rotation index is brought out so that a consumer can tell which mapping is in force.

Top module: `rot_xbar`

## Requirements
- R1: A synchronous active-high `rst` clears all outputs to zero and `rot_idx` to 0. This takes effect on the first rising edge at which `rst` is high.
- R2: On each rising edge without reset, output port j (ports 0..2 are `bank_out` slices, ports 3..5 are `dummy_out` slices, with port j at bits [16*j+15:16*j] of its bus) loads the word on input port (j + k) mod 6. Here k is the rotation index in force before that edge.
- R3: Input ports 0..2 are the slices of `src_word` (port i at bits [16*i+15:16*i]). Input ports 3..5 always read as zero. So `bank_out` is zero whenever k was 3, and `dummy_out` is zero whenever k was 0.
- R4: `rot_idx` holds its value for 256 consecutive cycles. It advances by one on the edge at which the phase counter rolls from 255 to 0, which is the 256th, 512th, … edge after reset is released.
- R5: `rot_idx` counts 0,1,2,3,4,5 and returns to 0 after 5. It never shows 6 or 7.
- R6: A new rotation index first steers the outputs on the edge after the one that advanced it.
- R7: Within 1536 cycles after reset, every live input has been routed to every one of the six outputs.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_word | input | 48 | Three live 16-bit input words, input port i at bits [16*i+15:16*i] |
| bank_out | output | 48 | Registered output ports 0..2 toward the counter bank |
| dummy_out | output | 48 | Registered output ports 3..5 toward the dummy loads |
| rot_idx | output | 3 | Current rotation index k (0..5) |

## Verification
The live inputs cycle through three word patterns: all ones, a single walking one that differs per input, and a word that tags the input number over a running cycle count. The tagged pattern catches a wrong or swapped source. The walking one exposes bit-slice misalignment. The all-ones pattern makes a zero tied input stand out on any output it reaches. Every output is compared each cycle over more than a full six-mapping schedule, so the checks cover each rotation boundary, the 5-to-0 wrap and the one-edge lag of a new mapping. A mid-schedule reset then checks that the sequence restarts from the identity mapping.

// File: rtl/rot_xbar.sv
module rot_xbar #(
  parameter int W     = 16,
  parameter int NPORT = 6,
  parameter int NLIVE = 3,
  parameter int NBANK = 3,
  parameter int CW    = 8,
  localparam int IW   = $clog2(NPORT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NLIVE*W-1:0]       src_word,
  output logic [NBANK*W-1:0]       bank_out,
  output logic [(NPORT-NBANK)*W-1:0] dummy_out,
  output logic [IW-1:0]            rot_idx
);

  localparam int NDUM = NPORT - NBANK;
  localparam logic [IW-1:0] LAST = IW'(NPORT - 1);

  logic [CW-1:0] phase;
  logic [IW-1:0] rot;
  logic [W-1:0]  in_w  [NPORT];
  logic [W-1:0]  out_q [NPORT];

  wire roll = &phase;

  function automatic logic [IW-1:0] pick(int j, logic [IW-1:0] k);
    int s;
    s = j + int'(k);
    if (s >= NPORT) s = s - NPORT;
    return IW'(s);
  endfunction

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    if (i < NLIVE) begin : g_live
      assign in_w[i] = src_word[i*W +: W];
    end else begin : g_tied
      assign in_w[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      rot   <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (roll) rot <= (rot == LAST) ? '0 : rot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NPORT; j++) begin
      if (rst) out_q[j] <= '0;
      else     out_q[j] <= in_w[pick(j, rot)];
    end
  end

  for (genvar j = 0; j < NBANK; j++) begin : g_bank
    assign bank_out[j*W +: W] = out_q[j];
  end
  for (genvar j = 0; j < NDUM; j++) begin : g_dum
    assign dummy_out[j*W +: W] = out_q[NBANK + j];
  end

  assign rot_idx = rot;

endmodule

// File: rtl/rot_xbar_chk.sv
module rot_xbar_chk #(
  parameter int W     = 16,
  parameter int NPORT = 6,
  parameter int NBANK = 3,
  parameter int CW    = 8,
  localparam int IW   = $clog2(NPORT)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NBANK*W-1:0]         bank_out,
  input logic [(NPORT-NBANK)*W-1:0] dummy_out,
  input logic [IW-1:0]              rot_idx,
  input logic [CW-1:0]              phase
);

  localparam logic [IW-1:0] LAST = IW'(NPORT - 1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (rot_idx == '0 && bank_out == '0 && dummy_out == '0)); // R1

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) rot_idx <= LAST); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (rot_idx != $past(rot_idx)) |-> (rot_idx == (($past(rot_idx) == LAST) ? '0 : $past(rot_idx) + 1'b1))); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst) (phase != '0) |-> $stable(rot_idx)); // R4

  AST_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rot_idx) == IW'(NBANK)) |-> bank_out == '0); // R3

  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rot_idx) == '0) |-> dummy_out == '0); // R3

endmodule

bind rot_xbar rot_xbar_chk #(.W(W), .NPORT(NPORT), .NBANK(NBANK), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bank_out(bank_out), .dummy_out(dummy_out),
  .rot_idx(rot_idx), .phase(phase)
);

// File: tb/sim_rot_xbar.sv
module sim_rot_xbar;
  localparam int CLK_NS = 10;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [47:0]   src_word = '0;
  logic [47:0]   bank_out;
  logic [47:0]   dummy_out;
  logic [2:0]    rot_idx;

  int tests = 0;
  int fails = 0;
  bit seen [6][3];

  rot_xbar u0 (.clk(clk), .rst(rst), .src_word(src_word),
               .bank_out(bank_out), .dummy_out(dummy_out), .rot_idx(rot_idx));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] pat(int n, int i);
    case (n % 3)
      0:       return 16'hFFFF;
      1:       return 16'h0001 << ((n + 5*i) % 16);
      default: return {4'(i + 1), 12'(n)};
    endcase
  endfunction

  function automatic logic [15:0] outp(int j);
    if (j < 3) return bank_out[j*W +: W];
    return dummy_out[(j-3)*W +: W];
  endfunction

  task automatic check(string req, int n, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s n=%0d got %h exp %h", req, n, got, exp);
    end
  endtask

  task automatic run(int ncyc);
    for (int n = 1; n <= ncyc; n++) begin
      for (int i = 0; i < 3; i++) src_word[i*W +: W] = pat(n, i);
      @(posedge clk);
      @(negedge clk);
      begin
        int kp = ((n - 1) / 256) % 6;
        string tag = ((n - 1) % 256 == 0 && n > 1) ? "R6" : (kp == 3 || kp == 0) ? "R3" : "R2";
        for (int j = 0; j < 6; j++) begin
          int s = (j + kp) % 6;
          logic [15:0] e = (s < 3) ? pat(n, s) : 16'h0;
          check(tag, n, outp(j), e);
          if (s < 3 && outp(j) == e) seen[j][s] = 1'b1;
        end
        check((n % 256 == 0) ? "R5" : "R4", n, 16'(rot_idx), 16'((n / 256) % 6));
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    src_word = {3{16'hA5A5}};
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", 0, bank_out[15:0] | bank_out[31:16] | bank_out[47:32], 16'h0);
    check("R1", 0, dummy_out[15:0] | dummy_out[31:16] | dummy_out[47:32], 16'h0);
    check("R1", 0, 16'(rot_idx), 16'h0);
    rst = 1'b0;
    run(1700);
    for (int j = 0; j < 6; j++)
      for (int s = 0; s < 3; s++)
        check("R7", j*3 + s, 16'(seen[j][s]), 16'h1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", 1, bank_out[15:0] | bank_out[31:16] | bank_out[47:32], 16'h0);
    check("R1", 1, dummy_out[15:0] | dummy_out[31:16] | dummy_out[47:32], 16'h0);
    check("R1", 1, 16'(rot_idx), 16'h0);
    rst = 1'b0;
    run(300);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule